// File: doc/BRIEF.md
# Quadrature Pulse Counter Unit

This block counts edges on two input signals. It holds the total in a signed 16-bit counter. The unit has two channels and they are wired crosswise. Channel 0 counts edges on input A and uses input B as its control level. Channel 1 counts edges on input B and uses input A as its control level.

Each channel has its own mode fields:
- one field for the rising edge and one for the falling edge, each choosing count up, count down or ignore;
- one field for each level of the control input, each choosing keep, reverse or hold.

When loaded with the reset-default modes, the pair decodes an A/B quadrature encoder in 4x mode, so every edge of either signal moves the count by one.

Both inputs are idle-high. Each input passes a two-flop synchronizer and then a glitch filter with a programmable threshold. The counter saturates at a programmable low limit and a programmable high limit. When the count lands on a limit, a sticky flag is set for that limit. A control bit holds the counter at zero while it is set. All settings and the count are reached through a small register port: a write strobe with an address, plus a combinational read address.

Top module: `qpc_unit`

Register map (16-bit words):
- Address 0: channel modes.
  - Channel 0 in bits [7:0], channel 1 in bits [15:8].
  - Within each byte: rising-edge action [1:0], falling-edge action [3:2], control-low action [5:4], control-high action [7:6].
  - Reset value 0x1916.
- Address 1: control.
  - Bit 0 holds the count at zero.
  - Bit 1 enables the filter.
  - Bits [15:8] are the filter threshold.
  - Reset value 0x0502.
- Address 2: low limit, reset value 0x8000.
- Address 3: high limit, reset value 0x7FFF.
- Address 4: count, read-only.
- Address 5: status. Bit 0 is the high-limit flag and bit 1 is the low-limit flag. Writing a 1 to a bit clears that flag.

## Requirements
- R1: After reset:
  - the count and status read 0;
  - mode, control, low limit and high limit read 0x1916, 0x0502, 0x8000 and 0x7FFF.
- R2: With the default modes, A leading B (AB 11→01→00→10→11) adds 1 per edge, so a full cycle adds 4.
- R3: With the default modes, B leading A subtracts 1 per edge.
- R4: Edge actions are coded 0 = none, 1 = increment, 2 = decrement, 3 = none. An edge whose action is none leaves the count unchanged.
- R5: Level actions are coded 0 = keep, 1 = reverse, 2 or 3 = hold. They are selected by the other input's level after the edge.
- R6: When both channels step in the same cycle, their sum is applied: +2 when both increment, 0 when one increments and the other decrements.
- R7: The count saturates at the programmed high and low limits, which are compared as signed values.
- R8: An update that leaves the count equal to the high (low) limit sets status bit 0 (bit 1). The flag stays set until a 1 is written to it.
- R9: With the filter on, a level lasting fewer than threshold cycles is ignored, and a level held longer is counted.
- R10: With the filter off, an input change appears in the count on the fourth rising clock edge after it.
- R11: While control bit 0 is set, the count is zero and edges are lost.
- R12: Values written to the limit registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Quadrature input A, idle-high |
| in_b | input | 1 | Quadrature input B, idle-high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |

## Verification
The bench builds the unit with its default parameters: a 16-bit count and an 8-bit filter threshold. This lets the reset-default threshold of 5 be checked against pulses of 4 and 6 cycles. With 16-bit limit registers, negative limits such as -2 can be programmed, which tests the signed saturation and both sticky flags within a few edges. Reprogramming the mode word exposes the individual edge and level actions, and the simultaneous steps that no quadrature signal can produce.

// File: rtl/qpc_pkg.sv
// Shared types and register addresses for the quadrature pulse counter.
package qpc_pkg;

    // Action taken on a pulse-input edge.
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_INC   = 2'd1,
        EDGE_DEC   = 2'd2,
        EDGE_NONE3 = 2'd3
    } edge_act_e;

    // Modifier chosen by the control-input level.
    typedef enum logic [1:0] {
        LVL_KEEP  = 2'd0,
        LVL_REV   = 2'd1,
        LVL_HOLD  = 2'd2,
        LVL_HOLD3 = 2'd3
    } lvl_act_e;

    // One channel's mode byte; the field positions match the register word.
    typedef struct packed {
        lvl_act_e  on_high;
        lvl_act_e  on_low;
        edge_act_e on_fall;
        edge_act_e on_rise;
    } chan_mode_t;

    localparam logic [2:0] ADDR_MODE  = 3'd0;
    localparam logic [2:0] ADDR_CTRL  = 3'd1;
    localparam logic [2:0] ADDR_LIMLO = 3'd2;
    localparam logic [2:0] ADDR_LIMHI = 3'd3;
    localparam logic [2:0] ADDR_COUNT = 3'd4;
    localparam logic [2:0] ADDR_STAT  = 3'd5;

    localparam logic [15:0] MODE_RESET = 16'h1916;
    localparam logic [15:0] CTRL_RESET = 16'h0502;

endpackage

// File: rtl/qpc_infilt.sv
// Input conditioner: a two-flop synchronizer followed by a stability filter.
// The output takes a new level only after the synchronized input has differed
// from it for THRESH consecutive cycles. A threshold of 0 behaves like 1.
// Assumes an idle-high input; all flops reset to 1.
module qpc_infilt #(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             en,
    input  logic [FLT_W-1:0] thresh,
    output logic             filt
);
    logic             s1, s2;
    logic [FLT_W-1:0] run;

    // Synchronize the raw pin, then qualify level changes against the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            filt <= 1'b1;
            run  <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (!en) begin
                filt <= s2;
                run  <= '0;
            end else if (s2 == filt) begin
                run <= '0;
            end else if (({1'b0, run} + (FLT_W+1)'(1)) >= {1'b0, thresh}) begin
                filt <= s2;
                run  <= '0;
            end else begin
                run <= run + FLT_W'(1);
            end
        end
    end
endmodule

// File: rtl/qpc_chan.sv
// One counting channel. It detects edges on its filtered pulse input, picks
// the edge action from its mode, and applies the modifier chosen by the
// current control level. The output is a signed step of -1, 0 or +1 for
// this cycle. Assumes both inputs are filtered, synchronous and idle-high.
module qpc_chan
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse,
    input  logic              ctrl,
    input  chan_mode_t        mode,
    output logic signed [1:0] step
);
    logic      pulse_d;
    edge_act_e act;
    lvl_act_e  lvl;

    // Remember the previous pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_d <= 1'b1;
        else        pulse_d <= pulse;
    end

    // Resolve the edge action and the level modifier into a signed step.
    always_comb begin
        act = EDGE_NONE;
        if (pulse && !pulse_d)      act = mode.on_rise;
        else if (!pulse && pulse_d) act = mode.on_fall;
        lvl = ctrl ? mode.on_high : mode.on_low;
        step = 2'sd0;
        if (lvl == LVL_KEEP || lvl == LVL_REV) begin
            if (act == EDGE_INC) step = (lvl == LVL_KEEP) ? 2'sd1 : -2'sd1;
            if (act == EDGE_DEC) step = (lvl == LVL_KEEP) ? -2'sd1 : 2'sd1;
        end
    end
endmodule

// File: rtl/qpc_count.sv
// Saturating signed counter with sticky limit flags. It adds the net step
// of both channels, clamps the result to [lim_lo, lim_hi], and flags an
// update that lands on a limit. A hold input forces zero.
// Assumes lim_lo <= lim_hi.
module qpc_count #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic signed [2:0]       net_step,
    input  logic signed [CNT_W-1:0] lim_lo,
    input  logic signed [CNT_W-1:0] lim_hi,
    input  logic [1:0]              clr_flags,
    output logic signed [CNT_W-1:0] count,
    output logic                    flag_hi,
    output logic                    flag_lo
);
    localparam int SUM_W = CNT_W + 2;

    logic signed [SUM_W-1:0] sum, lo_x, hi_x;
    logic signed [CNT_W-1:0] nxt;

    // Sign-extend, add the step and clamp to the limits.
    always_comb begin
        sum  = $signed({count[CNT_W-1], count[CNT_W-1], count})
             + $signed({{(SUM_W-3){net_step[2]}}, net_step});
        lo_x = $signed({lim_lo[CNT_W-1], lim_lo[CNT_W-1], lim_lo});
        hi_x = $signed({lim_hi[CNT_W-1], lim_hi[CNT_W-1], lim_hi});
        if (sum > hi_x)      nxt = lim_hi;
        else if (sum < lo_x) nxt = lim_lo;
        else                 nxt = sum[CNT_W-1:0];
    end

    // Update the count and the sticky flags; a flag set wins over its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            flag_hi <= 1'b0;
            flag_lo <= 1'b0;
        end else begin
            if (hold)               count <= '0;
            else if (net_step != 0) count <= nxt;
            flag_hi <= (flag_hi && !clr_flags[0]) || (!hold && net_step != 0 && nxt == lim_hi);
            flag_lo <= (flag_lo && !clr_flags[1]) || (!hold && net_step != 0 && nxt == lim_lo);
        end
    end
endmodule

// File: rtl/qpc_unit.sv
// Top of the two-channel quadrature pulse counter. It owns the register
// port, conditions both inputs, and wires the channels crosswise
// (channel 0: pulse A, control B; channel 1: pulse B, control A).
// Assumes CNT_W >= 16 so the mode and control words fit in one register.
module qpc_unit
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data
);
    localparam int NCH = 2;

    logic [15:0]             mode_q;
    logic [15:0]             ctrl_q;
    logic signed [CNT_W-1:0] lim_lo_q, lim_hi_q;
    logic [NCH-1:0]          raw_in, filt_in;
    logic signed [1:0]       ch_step [NCH];
    logic signed [2:0]       net_step;
    logic [1:0]              clr_flags;
    logic signed [CNT_W-1:0] cnt_val;
    logic                    flag_hi, flag_lo;
    logic                    ctl_hold;
    chan_mode_t              ch_mode [NCH];

    assign raw_in   = {in_b, in_a};
    assign ctl_hold = ctrl_q[0];
    assign ch_mode[0] = chan_mode_t'(mode_q[7:0]);
    assign ch_mode[1] = chan_mode_t'(mode_q[15:8]);

    // Configuration registers written through the strobe port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            ctrl_q   <= CTRL_RESET;
            lim_lo_q <= {1'b1, {(CNT_W-1){1'b0}}};
            lim_hi_q <= {1'b0, {(CNT_W-1){1'b1}}};
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_MODE:  mode_q   <= cfg_wdata[15:0];
                ADDR_CTRL:  ctrl_q   <= cfg_wdata[15:0];
                ADDR_LIMLO: lim_lo_q <= cfg_wdata;
                ADDR_LIMHI: lim_hi_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign clr_flags = (cfg_we && cfg_addr == ADDR_STAT) ? cfg_wdata[1:0] : 2'b00;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            qpc_infilt #(.FLT_W(FLT_W)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw    (raw_in[gi]),
                .en     (ctrl_q[1]),
                .thresh (ctrl_q[8 +: FLT_W]),
                .filt   (filt_in[gi])
            );
            qpc_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .pulse (filt_in[gi]),
                .ctrl  (filt_in[NCH-1-gi]),
                .mode  (ch_mode[gi]),
                .step  (ch_step[gi])
            );
        end
    endgenerate

    assign net_step = {ch_step[0][1], ch_step[0]} + {ch_step[1][1], ch_step[1]};

    qpc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (ctl_hold),
        .net_step  (net_step),
        .lim_lo    (lim_lo_q),
        .lim_hi    (lim_hi_q),
        .clr_flags (clr_flags),
        .count     (cnt_val),
        .flag_hi   (flag_hi),
        .flag_lo   (flag_lo)
    );

    // Readback multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_MODE:  rd_data[15:0] = mode_q;
            ADDR_CTRL:  rd_data[15:0] = ctrl_q;
            ADDR_LIMLO: rd_data = lim_lo_q;
            ADDR_LIMHI: rd_data = lim_hi_q;
            ADDR_COUNT: rd_data = cnt_val;
            ADDR_STAT:  rd_data[1:0] = {flag_lo, flag_hi};
            default: ;
        endcase
    end
endmodule

// File: rtl/qpc_unit_chk.sv
// Checker bound to qpc_unit. It observes the hold control, the net step
// and the counter state; it drives nothing.
module qpc_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hold,
    input logic signed [2:0]       net_step,
    input logic signed [CNT_W-1:0] count,
    input logic signed [CNT_W-1:0] lim_lo,
    input logic signed [CNT_W-1:0] lim_hi,
    input logic                    flag_hi,
    input logic                    flag_lo,
    input logic [1:0]              clr_flags
);
    assert_hold_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0));

    assert_no_step_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && net_step == 3'sd0) |=> $stable(count));

    assert_within_limits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && net_step != 3'sd0) |=> (count >= $past(lim_lo) && count <= $past(lim_hi)));

    assert_hi_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hi && !clr_flags[0]) |=> flag_hi);

    assert_lo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && !clr_flags[1]) |=> flag_lo);
endmodule

bind qpc_unit qpc_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (ctl_hold),
    .net_step  (net_step),
    .count     (cnt_val),
    .lim_lo    (lim_lo_q),
    .lim_hi    (lim_hi_q),
    .flag_hi   (flag_hi),
    .flag_lo   (flag_lo),
    .clr_flags (clr_flags)
);

// File: tb/qpc_unit_bench.sv
module qpc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_a = 1'b1, in_b = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0, rd_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] rd_data;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    qpc_unit u_qpc_unit (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Quadrature walk: {a, b, expected count}. Forward (R2), then reverse (R3).
    localparam logic [17:0] VEC [18] = '{
        {2'b01, 16'd1}, {2'b00, 16'd2}, {2'b10, 16'd3}, {2'b11, 16'd4},
        {2'b01, 16'd5}, {2'b00, 16'd6}, {2'b10, 16'd7}, {2'b11, 16'd8},
        {2'b10, 16'd7}, {2'b00, 16'd6}, {2'b01, 16'd5}, {2'b11, 16'd4},
        {2'b10, 16'd3}, {2'b00, 16'd2}, {2'b01, 16'd1}, {2'b11, 16'd0},
        {2'b10, 16'hFFFF}, {2'b00, 16'hFFFE}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive(input logic a, input logic b, input int settle);
        @(negedge clk);
        in_a = a; in_b = b;
        repeat (settle) @(posedge clk);
    endtask

    task automatic zero_count();
        wr(3'd1, 16'h0503);
        wr(3'd1, 16'h0502);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(3'd4, v); chk("R1 count", v, 16'h0000);
        rd(3'd5, v); chk("R1 status", v, 16'h0000);
        rd(3'd0, v); chk("R1 mode", v, 16'h1916);
        rd(3'd1, v); chk("R1 ctrl", v, 16'h0502);
        rd(3'd2, v); chk("R1 lim_lo", v, 16'h8000);
        rd(3'd3, v); chk("R1 lim_hi", v, 16'h7FFF);

        // R2 / R3 quadrature table
        for (int i = 0; i < 18; i++) begin
            drive(VEC[i][17], VEC[i][16], 12);
            rd(3'd4, v);
            chk(i < 8 ? "R2 forward" : "R3 reverse", v, VEC[i][15:0]);
        end

        // R11 hold at zero, edges lost (AB = 00, count -2)
        wr(3'd1, 16'h0503);
        rd(3'd4, v); chk("R11 held", v, 16'h0000);
        drive(1, 0, 12); drive(1, 1, 12);
        rd(3'd4, v); chk("R11 edges lost", v, 16'h0000);
        wr(3'd1, 16'h0502);
        repeat (12) @(posedge clk);
        rd(3'd4, v); chk("R11 released", v, 16'h0000);

        // R9 glitch filter (threshold 5)
        drive(0, 1, 4); drive(1, 1, 12);
        rd(3'd4, v); chk("R9 short low rejected", v, 16'h0000);
        drive(0, 1, 6); drive(0, 1, 12);
        rd(3'd4, v); chk("R9 long low counted", v, 16'h0001);
        drive(1, 1, 4); drive(0, 1, 12);
        rd(3'd4, v); chk("R9 short high rejected", v, 16'h0001);

        // R10 filter off: change visible on the 4th edge
        wr(3'd1, 16'h0500);
        @(negedge clk); in_a = 1'b1;
        repeat (3) @(posedge clk);
        #1 rd_addr = 3'd4; #1 chk("R10 before 4th edge", rd_data, 16'h0001);
        @(posedge clk);
        #1 chk("R10 at 4th edge", rd_data, 16'h0000);
        wr(3'd1, 16'h0502);

        // R12 / R7 / R8 limits (AB = 11, count 0)
        wr(3'd2, 16'hFFFE); wr(3'd3, 16'h0003);
        rd(3'd2, v); chk("R12 lim_lo", v, 16'hFFFE);
        rd(3'd3, v); chk("R12 lim_hi", v, 16'h0003);
        drive(0, 1, 12); drive(0, 0, 12); drive(1, 0, 12); drive(1, 1, 12); drive(0, 1, 12);
        rd(3'd4, v); chk("R7 saturate high", v, 16'h0003);
        rd(3'd5, v); chk("R8 high flag", v, 16'h0001);
        wr(3'd5, 16'h0001);
        rd(3'd5, v); chk("R8 flag cleared", v, 16'h0000);
        drive(1, 1, 12); drive(1, 0, 12); drive(0, 0, 12); drive(0, 1, 12); drive(1, 1, 12); drive(1, 0, 12);
        rd(3'd4, v); chk("R7 saturate low", v, 16'hFFFE);
        rd(3'd5, v); chk("R8 low flag only", v, 16'h0002);
        wr(3'd2, 16'h8000); wr(3'd3, 16'h7FFF);

        // R4 / R5 modes (AB = 10)
        wr(3'd0, 16'h0021); zero_count();
        drive(1, 1, 12); drive(0, 1, 12);
        rd(3'd4, v); chk("R4 none actions", v, 16'h0000);
        drive(1, 1, 12);
        rd(3'd4, v); chk("R4 rise increments", v, 16'h0001);
        drive(1, 0, 12); drive(0, 0, 12); drive(1, 0, 12);
        rd(3'd4, v); chk("R5 hold on low", v, 16'h0001);
        wr(3'd0, 16'h0011);
        drive(0, 0, 12); drive(1, 0, 12);
        rd(3'd4, v); chk("R5 reverse on low", v, 16'h0000);

        // R6 simultaneous steps
        wr(3'd0, 16'h0000); drive(0, 0, 12); zero_count();
        wr(3'd0, 16'h0101); drive(1, 1, 12);
        rd(3'd4, v); chk("R6 net +2", v, 16'h0002);
        wr(3'd0, 16'h0201); drive(0, 0, 12); drive(1, 1, 12);
        rd(3'd4, v); chk("R6 net 0", v, 16'h0002);

        // R1 reset again
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        rd(3'd4, v); chk("R1 count after reset", v, 16'h0000);
        rd(3'd0, v); chk("R1 mode after reset", v, 16'h1916);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule